// File: doc/BRIEF.md
# Periodic Split-Transaction Micro-Frame Scheduler

This block sits in a host controller's periodic path. For each queue head offered to it, the block decides whether a split transaction is due in the current micro-frame. A split transaction is either a start-split or a complete-split. When one is due, the block emits a split-token request. The request carries the hub address, the hub port, a start/complete flag and the interrupt endpoint type.

The queue head supplies four things: its speed code, an eight-bit start-split mask and an eight-bit complete-split mask, together with its hub and port. A queue head counts as a full/low-speed interrupt endpoint only when its speed is full or low and its start mask is non-zero. Every other queue head produces nothing.

The micro-frame number is taken from the host frame counter at each micro-frame boundary strobe. When both masks select the current slot, the complete-split goes out first and the start-split goes out on the next cycle. A start-split still waiting when the next boundary arrives is discarded, because split phases that miss their slot are never deferred.

Top module: `psplit_sched`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself: after that edge `tok_valid` is 0, `qh_ready` is 1 and the latched micro-frame number is 0.
- R2: A queue head is eligible only when `qh_speed` is 2'b00 (full speed) or 2'b01 (low speed) and `qh_smask` is non-zero. Speed 2'b10 (high speed), speed 2'b11 (invalid) and an all-zero start mask never produce a token.
- R3: Every token is a split token with `tok_ep_type` = 2'b11 (interrupt). The type codes are 00 control, 01 isochronous, 10 bulk and 11 interrupt.
- R4: An accepted eligible queue head yields a start-split token (`tok_complete` = 0) only when bit u of `qh_smask` is set, where u is the latched micro-frame number 0..7.
- R5: An accepted eligible queue head yields a complete-split token (`tok_complete` = 1) only when bit u of `qh_cmask` is set.
- R6: The latched micro-frame number takes `frame_index[2:0]` only in a cycle where `uframe_tick` is high. It keeps that value until the next strobe, and every evaluation uses it.
- R7: A queue head is accepted in a cycle where `qh_valid` and `qh_ready` are both high. Its first token has `tok_valid` high in the following cycle. When both masks select u, the complete-split token comes first and the start-split token follows in the next cycle, and `qh_ready` is 0 in between.
- R8: A start-split still pending when `uframe_tick` is high is dropped. No start token follows, and `qh_ready` returns to 1.
- R9: `tok_hub` and `tok_port` equal the `qh_hub` and `qh_port` of the accepted queue head, for both tokens.
- R10: `qh_valid` is ignored while `qh_ready` is 0. Such a queue head produces no token and does not change the pending token's hub or port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uframe_tick | input | 1 | Micro-frame boundary strobe |
| frame_index | input | FIDX_W | Host frame index counter |
| qh_valid | input | 1 | Queue head offered this cycle |
| qh_ready | output | 1 | Block can accept a queue head |
| qh_speed | input | 2 | Endpoint speed code |
| qh_smask | input | 8 | Start-split micro-frame mask |
| qh_cmask | input | 8 | Complete-split micro-frame mask |
| qh_hub | input | HUB_W | Hub address |
| qh_port | input | PORT_W | Hub port number |
| tok_valid | output | 1 | Split-token request valid |
| tok_complete | output | 1 | 0 start-split, 1 complete-split |
| tok_ep_type | output | 2 | Endpoint type code |
| tok_hub | output | HUB_W | Hub address of the token |
| tok_port | output | PORT_W | Port number of the token |

## Verification
A wrong latched micro-frame number shows up on the first queue head evaluated after the strobe. Such a queue head either gets a token whose mask bit is clear or loses one whose bit is set, one cycle after acceptance. A stuck pending start shows at the ports as `qh_ready` held low, or as a start token after a boundary that should have dropped it, within two cycles. Wrong ordering appears as `tok_complete` reading 0 on the first token of a dual-hit queue head.

// File: rtl/psplit_pkg.sv
package psplit_pkg;
  localparam int UFRAMES = 8;
  localparam int UF_W    = $clog2(UFRAMES);

  typedef enum logic [1:0] {
    SPD_FULL = 2'b00,
    SPD_LOW  = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_BAD  = 2'b11
  } speed_e;

  typedef enum logic [1:0] {
    ET_CTRL  = 2'b00,
    ET_ISO   = 2'b01,
    ET_BULK  = 2'b10,
    ET_INTR  = 2'b11
  } eptype_e;
endpackage

// File: rtl/psplit_classify.sv
module psplit_classify
  import psplit_pkg::*;
#(
  parameter int MASK_W = UFRAMES
) (
  input  logic [1:0]        speed,
  input  logic [MASK_W-1:0] smask,
  output logic              is_intr,
  output logic [1:0]        ep_code
);
  logic slow;
  always_comb begin
    slow    = (speed == SPD_FULL) || (speed == SPD_LOW);
    is_intr = slow && (smask != '0);
    ep_code = is_intr ? ET_INTR : ET_BULK;
  end
endmodule

// File: rtl/psplit_slot.sv
module psplit_slot
  import psplit_pkg::*;
#(
  parameter int FIDX_W = 14,
  parameter int MASK_W = UFRAMES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [FIDX_W-1:0] fidx,
  input  logic [MASK_W-1:0] smask,
  input  logic [MASK_W-1:0] cmask,
  output logic              s_hit,
  output logic              c_hit
);
  localparam int IW = $clog2(MASK_W);
  logic [IW-1:0] uframe_q;

  always_ff @(posedge clk) begin
    if (rst)       uframe_q <= '0;
    else if (tick) uframe_q <= fidx[IW-1:0];
  end

  always_comb begin
    s_hit = smask[uframe_q];
    c_hit = cmask[uframe_q];
  end
endmodule

// File: rtl/psplit_issue.sv
module psplit_issue #(
  parameter int HUB_W  = 7,
  parameter int PORT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              qh_valid,
  input  logic              eligible,
  input  logic [1:0]        ep_code,
  input  logic              s_hit,
  input  logic              c_hit,
  input  logic [HUB_W-1:0]  hub,
  input  logic [PORT_W-1:0] port,
  output logic              ready,
  output logic              tok_valid,
  output logic              tok_complete,
  output logic [1:0]        tok_ep_type,
  output logic [HUB_W-1:0]  tok_hub,
  output logic [PORT_W-1:0] tok_port
);
  logic              pend_q;
  logic [1:0]        pend_ep_q;
  logic [HUB_W-1:0]  pend_hub_q;
  logic [PORT_W-1:0] pend_port_q;
  logic              accept;

  assign ready  = !pend_q;
  assign accept = qh_valid && ready && eligible && (s_hit || c_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      tok_valid    <= 1'b0;
      tok_complete <= 1'b0;
      tok_ep_type  <= '0;
      tok_hub      <= '0;
      tok_port     <= '0;
      pend_ep_q    <= '0;
      pend_hub_q   <= '0;
      pend_port_q  <= '0;
    end else begin
      tok_valid <= 1'b0;
      if (pend_q) begin
        pend_q <= 1'b0;
        if (!tick) begin
          tok_valid    <= 1'b1;
          tok_complete <= 1'b0;
          tok_ep_type  <= pend_ep_q;
          tok_hub      <= pend_hub_q;
          tok_port     <= pend_port_q;
        end
      end else if (accept) begin
        tok_valid    <= 1'b1;
        tok_complete <= c_hit;
        tok_ep_type  <= ep_code;
        tok_hub      <= hub;
        tok_port     <= port;
        pend_q       <= c_hit && s_hit;
        pend_ep_q    <= ep_code;
        pend_hub_q   <= hub;
        pend_port_q  <= port;
      end
    end
  end
endmodule

// File: rtl/psplit_sched.sv
module psplit_sched
  import psplit_pkg::*;
#(
  parameter int FIDX_W = 14,
  parameter int HUB_W  = 7,
  parameter int PORT_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               uframe_tick,
  input  logic [FIDX_W-1:0]  frame_index,
  input  logic               qh_valid,
  output logic               qh_ready,
  input  logic [1:0]         qh_speed,
  input  logic [UFRAMES-1:0] qh_smask,
  input  logic [UFRAMES-1:0] qh_cmask,
  input  logic [HUB_W-1:0]   qh_hub,
  input  logic [PORT_W-1:0]  qh_port,
  output logic               tok_valid,
  output logic               tok_complete,
  output logic [1:0]         tok_ep_type,
  output logic [HUB_W-1:0]   tok_hub,
  output logic [PORT_W-1:0]  tok_port
);
  logic       is_intr;
  logic [1:0] ep_code;
  logic       s_hit, c_hit;

  psplit_classify #(.MASK_W(UFRAMES)) u_class (
    .speed(qh_speed), .smask(qh_smask), .is_intr(is_intr), .ep_code(ep_code)
  );

  psplit_slot #(.FIDX_W(FIDX_W), .MASK_W(UFRAMES)) u_slot (
    .clk(clk), .rst(rst), .tick(uframe_tick), .fidx(frame_index),
    .smask(qh_smask), .cmask(qh_cmask), .s_hit(s_hit), .c_hit(c_hit)
  );

  psplit_issue #(.HUB_W(HUB_W), .PORT_W(PORT_W)) u_issue (
    .clk(clk), .rst(rst), .tick(uframe_tick), .qh_valid(qh_valid),
    .eligible(is_intr), .ep_code(ep_code), .s_hit(s_hit), .c_hit(c_hit),
    .hub(qh_hub), .port(qh_port), .ready(qh_ready),
    .tok_valid(tok_valid), .tok_complete(tok_complete),
    .tok_ep_type(tok_ep_type), .tok_hub(tok_hub), .tok_port(tok_port)
  );
endmodule

// File: rtl/psplit_sched_chk.sv
module psplit_sched_chk (
  input logic       clk,
  input logic       rst,
  input logic       uframe_tick,
  input logic       qh_valid,
  input logic       qh_ready,
  input logic [1:0] qh_speed,
  input logic       tok_valid,
  input logic       tok_complete
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!tok_valid && qh_ready));

  p_fast_or_bad_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (qh_valid && qh_ready && qh_speed[1]) |=> !tok_valid);

  p_complete_first_r7: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !qh_ready) |-> tok_complete);

  p_start_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (!qh_ready && !uframe_tick) |=> (tok_valid && !tok_complete));

  p_pending_dropped_r8: assert property (@(posedge clk) disable iff (rst)
    (!qh_ready && uframe_tick) |=> (!tok_valid && qh_ready));

  p_token_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
    tok_valid |-> $past(qh_valid || !qh_ready));
endmodule

bind psplit_sched psplit_sched_chk u_chk (
  .clk(clk), .rst(rst), .uframe_tick(uframe_tick), .qh_valid(qh_valid),
  .qh_ready(qh_ready), .qh_speed(qh_speed), .tok_valid(tok_valid),
  .tok_complete(tok_complete)
);

// File: tb/psplit_sched_bench.sv
module psplit_sched_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        uframe_tick;
  logic [13:0] frame_index;
  logic        qh_valid;
  logic        qh_ready;
  logic [1:0]  qh_speed;
  logic [7:0]  qh_smask, qh_cmask;
  logic [6:0]  qh_hub, qh_port;
  logic        tok_valid, tok_complete;
  logic [1:0]  tok_ep_type;
  logic [6:0]  tok_hub, tok_port;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  psplit_sched u_psplit_sched (
    .clk(clk), .rst(rst), .uframe_tick(uframe_tick), .frame_index(frame_index),
    .qh_valid(qh_valid), .qh_ready(qh_ready), .qh_speed(qh_speed),
    .qh_smask(qh_smask), .qh_cmask(qh_cmask), .qh_hub(qh_hub), .qh_port(qh_port),
    .tok_valid(tok_valid), .tok_complete(tok_complete), .tok_ep_type(tok_ep_type),
    .tok_hub(tok_hub), .tok_port(tok_port)
  );

  typedef struct packed {
    logic [1:0] spd;
    logic [7:0] sm;
    logic [7:0] cm;
    logic [2:0] uf;
    logic       ec;
    logic       es;
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{2'b00, 8'h01, 8'h00, 3'd0, 1'b0, 1'b1},
    '{2'b01, 8'h02, 8'h1C, 3'd1, 1'b0, 1'b1},
    '{2'b00, 8'h02, 8'h1C, 3'd3, 1'b1, 1'b0},
    '{2'b00, 8'h08, 8'h08, 3'd3, 1'b1, 1'b1},
    '{2'b10, 8'hFF, 8'hFF, 3'd5, 1'b0, 1'b0},
    '{2'b11, 8'hFF, 8'hFF, 3'd5, 1'b0, 1'b0},
    '{2'b00, 8'h00, 8'hFF, 3'd2, 1'b0, 1'b0},
    '{2'b01, 8'h80, 8'h01, 3'd7, 1'b0, 1'b1},
    '{2'b01, 8'h80, 8'h01, 3'd0, 1'b1, 1'b0},
    '{2'b00, 8'h10, 8'hE0, 3'd4, 1'b0, 1'b1},
    '{2'b00, 8'h10, 8'hE0, 3'd6, 1'b1, 1'b0},
    '{2'b00, 8'h20, 8'h04, 3'd1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_to(input logic [13:0] fi);
    uframe_tick = 1'b1; frame_index = fi;
    @(negedge clk);
    uframe_tick = 1'b0;
  endtask

  task automatic offer(input logic [1:0] s, input logic [7:0] sm, input logic [7:0] cm,
                       input logic [6:0] h, input logic [6:0] p);
    qh_valid = 1'b1; qh_speed = s; qh_smask = sm; qh_cmask = cm; qh_hub = h; qh_port = p;
  endtask

  task automatic expect_tok(input bit v, input bit c, input logic [6:0] h,
                            input logic [6:0] p, input string req);
    check(tok_valid == v, req, tok_valid, v);
    if (v) begin
      check(tok_complete == c, req, tok_complete, c);
      check(tok_ep_type == 2'b11, "R3 ep type", tok_ep_type, 2'b11);
      check(tok_hub == h && tok_port == p, "R9 hub/port", {tok_hub, tok_port}, {h, p});
    end
  endtask

  initial begin
    rst = 1'b1; uframe_tick = 1'b0; frame_index = '0; qh_valid = 1'b0;
    qh_speed = '0; qh_smask = '0; qh_cmask = '0; qh_hub = '0; qh_port = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(tok_valid == 1'b0, "R1 tok_valid", tok_valid, 0);
    check(qh_ready == 1'b1, "R1 qh_ready", qh_ready, 1);
    // R1: micro-frame number cleared to 0, so slot 0 is used
    offer(2'b00, 8'h01, 8'h00, 7'd9, 7'd9);
    @(negedge clk); qh_valid = 1'b0;
    expect_tok(1'b1, 1'b0, 7'd9, 7'd9, "R1 uframe zero");
    @(negedge clk);

    // R2 R4 R5 R7: vector walk
    for (int i = 0; i < 12; i++) begin
      logic [6:0] h, p;
      h = 7'(i + 3); p = 7'(i * 5);
      tick_to({11'(i * 37 + 1), VEC[i].uf});
      offer(VEC[i].spd, VEC[i].sm, VEC[i].cm, h, p);
      @(negedge clk); qh_valid = 1'b0;
      if (VEC[i].ec)      expect_tok(1'b1, 1'b1, h, p, "R5/R7 complete first");
      else if (VEC[i].es) expect_tok(1'b1, 1'b0, h, p, "R4 start");
      else                expect_tok(1'b0, 1'b0, h, p, "R2 no token");
      @(negedge clk);
      if (VEC[i].ec && VEC[i].es) expect_tok(1'b1, 1'b0, h, p, "R7 start second");
      else                        expect_tok(1'b0, 1'b0, h, p, "R7 single token");
    end

    // R6: index sampled only on the strobe
    tick_to(14'h3FFA);
    frame_index = 14'h0007;
    offer(2'b01, 8'h04, 8'h00, 7'd20, 7'd21);
    @(negedge clk); qh_valid = 1'b0;
    expect_tok(1'b1, 1'b0, 7'd20, 7'd21, "R6 held slot 2");
    @(negedge clk);
    offer(2'b01, 8'h80, 8'h00, 7'd20, 7'd21);
    @(negedge clk); qh_valid = 1'b0;
    expect_tok(1'b0, 1'b0, 7'd20, 7'd21, "R6 no strobe no change");
    @(negedge clk);

    // R7 R10: busy while pending, offer ignored
    offer(2'b00, 8'h04, 8'h04, 7'd40, 7'd41);
    @(negedge clk);
    expect_tok(1'b1, 1'b1, 7'd40, 7'd41, "R7 complete");
    check(qh_ready == 1'b0, "R7 busy", qh_ready, 0);
    offer(2'b01, 8'h04, 8'h04, 7'd50, 7'd51);
    @(negedge clk); qh_valid = 1'b0;
    expect_tok(1'b1, 1'b0, 7'd40, 7'd41, "R10 pending kept");
    @(negedge clk);
    expect_tok(1'b0, 1'b0, 7'd0, 7'd0, "R10 ignored offer");

    // R8: pending start dropped at boundary
    offer(2'b00, 8'h04, 8'h04, 7'd60, 7'd61);
    @(negedge clk); qh_valid = 1'b0;
    expect_tok(1'b1, 1'b1, 7'd60, 7'd61, "R8 complete");
    tick_to(14'h0002);
    expect_tok(1'b0, 1'b0, 7'd0, 7'd0, "R8 start dropped");
    check(qh_ready == 1'b1, "R8 ready back", qh_ready, 1);
    @(negedge clk);
    expect_tok(1'b0, 1'b0, 7'd0, 7'd0, "R8 no late start");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule